// File: doc/BRIEF.md
# Address Breakpoint and PC Capture Unit

This block watches a CPU bus and stops the program when a chosen kind of access reaches a programmed 16-bit address. It can also stop the program when an operator presses a button. The address and the kind of access are set through an I/O write interface. Four kinds of access can be watched: memory read, memory write, I/O input and I/O output.

When a trigger occurs, the unit does not stop the program at once. It waits until the current instruction has completed, which it sees as the next opcode fetch. At that fetch it raises a non-maskable interrupt request for a fixed number of clocks and stores the fetch address, which is the program counter of the next instruction. Software then reads the stored value from one I/O port, low byte first and high byte second.

After a break, and after reset, the unit is disarmed. It ignores every trigger until software writes the mode register again.

Top module: `brk_pc_unit`

## Requirements
- R1: After reset, `nmi_req` is 0 and the unit is disarmed. No address match and no button press causes a break until the mode port (0xFE) is written. Writing only the address ports does not arm the unit.
- R2: The break address is 16 bits. A write to port 0xFC loads bits 15:8 and a write to port 0xFD loads bits 7:0. A match needs all 16 bits of `bus_addr` to be equal.
- R3: A write to port 0xFE arms the unit and selects the break kind:
  - 0x0A: memory read (`bus_mem`=1 and `bus_rd`).
  - 0x06: memory write (`bus_mem`=1 and `bus_wr`).
  - 0x09: I/O input (`bus_mem`=0 and `bus_rd`).
  - 0x05: I/O output (`bus_mem`=0 and `bus_wr`).
  - Any other code, including 0x00, disables the address break.
- R4: A trigger is held pending. The break happens on the first `bus_fetch` cycle after the trigger cycle. A fetch in the same cycle as the trigger does not complete it.
- R5: On a break, `nmi_req` goes high in the cycle after the completing fetch. It stays high for exactly NMI_CYCLES clocks (4 by default).
- R6: On a break, the `bus_addr` of the completing fetch is stored. Successive read strobes to port 0xF2 return its low byte, then its high byte, then the low byte again, and so on. Every new capture sets the byte order back to low first.
- R7: A break disarms the unit. Later matches and button presses are ignored until port 0xFE is written. A write to 0xFE also drops any trigger that is still pending.
- R8: The `brk_btn` input is synchronized and edge-detected. One press of an armed unit gives exactly one break, which also waits for the next fetch. The button works whatever the break kind is.
- R9: Writes to any port other than 0xFC, 0xFD and 0xFE have no effect. `rd_data` is 0 in every cycle that is not a read of port 0xF2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe for the control ports |
| io_rd | input | 1 | I/O read strobe for the capture port |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| rd_data | output | 8 | Byte of the captured PC, 0 when not read |
| bus_addr | input | 16 | Observed bus address |
| bus_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_rd | input | 1 | Observed read strobe |
| bus_wr | input | 1 | Observed write strobe |
| bus_fetch | input | 1 | Opcode fetch marker |
| brk_btn | input | 1 | Manual break button, asynchronous, active high |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |

## Verification
The assertions assume that each observed access is a single-cycle strobe, and that `bus_fetch` comes only with a memory read of the fetch address. They also assume that software does not re-arm the unit and cause a second break while an NMI pulse is still in progress. The stimulus issues every bus access and port access as a one-cycle strobe, never drives `io_rd` and `io_wr` together, and waits until a pulse is over before writing the mode port again. The button is held steady for several clocks at each press, so the synchronizer sees clean edges.

// File: rtl/brk_pkg.sv
// Package brk_pkg
// Shared types and decode for the breakpoint unit.
// Assumes 8-bit control codes as seen on the I/O write bus.
package brk_pkg;

    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_MRD  = 3'd1,
        BK_MWR  = 3'd2,
        BK_IIN  = 3'd3,
        BK_IOUT = 3'd4
    } brk_kind_e;

    // Translate a mode byte into the kind of access to watch.
    function automatic brk_kind_e decode_kind(input logic [7:0] code);
        case (code)
            8'h0A:   decode_kind = BK_MRD;
            8'h06:   decode_kind = BK_MWR;
            8'h09:   decode_kind = BK_IIN;
            8'h05:   decode_kind = BK_IOUT;
            default: decode_kind = BK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/brk_btn_sync.sv
// Module brk_btn_sync
// Brings an asynchronous button into the clock domain and gives a
// one-cycle pulse on each rising edge of the synchronized level.
// Assumes the button is held steady longer than STAGES+1 clocks.
module brk_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    logic [STAGES-1:0] chain;
    logic              last_lvl;

    // First synchronizer flop samples the raw button.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= btn_raw;
    end

    // The remaining synchronizer flops.
    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronized level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_lvl <= 1'b0;
        else        last_lvl <= chain[STAGES-1];
    end

    // Rising edge of the synchronized level.
    assign press = chain[STAGES-1] & ~last_lvl;

endmodule

// File: rtl/brk_match.sv
// Module brk_match
// Combinational comparator: flags an observed access of the selected
// kind at the programmed address. Assumes single-cycle strobes.
module brk_match
    import brk_pkg::*;
#(
    parameter int AW = 16
) (
    input  brk_kind_e         kind,
    input  logic [AW-1:0]     brk_addr,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_mem,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              hit
);
    logic kind_ok;

    // Check that the access type agrees with the selected kind.
    always_comb begin
        case (kind)
            BK_MRD:  kind_ok = bus_mem  & bus_rd;
            BK_MWR:  kind_ok = bus_mem  & bus_wr;
            BK_IIN:  kind_ok = ~bus_mem & bus_rd;
            BK_IOUT: kind_ok = ~bus_mem & bus_wr;
            default: kind_ok = 1'b0;
        endcase
    end

    assign hit = kind_ok & (bus_addr == brk_addr);

endmodule

// File: rtl/brk_capture.sv
// Module brk_capture
// Holds the captured program counter, the byte selector for the read
// port and the NMI pulse counter. Assumes fire is a one-cycle pulse.
module brk_capture #(
    parameter int DW         = 8,
    parameter int NMI_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [2*DW-1:0] fetch_addr,
    input  logic            rd_strobe,
    output logic            nmi_req,
    output logic [DW-1:0]   rd_byte
);
    localparam int CW = $clog2(NMI_CYCLES + 1);

    logic [2*DW-1:0] pc_q;
    logic            hi_sel;
    logic [CW-1:0]   pulse_cnt;

    // Store the fetch address at the moment of the break.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc_q <= '0;
        else if (fire) pc_q <= fetch_addr;
    end

    // Byte selector: low after a capture, flips on each read.
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_sel <= 1'b0;
        else if (fire)      hi_sel <= 1'b0;
        else if (rd_strobe) hi_sel <= ~hi_sel;
    end

    // Counts down the remaining cycles of the NMI pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)              pulse_cnt <= '0;
        else if (fire)           pulse_cnt <= CW'(NMI_CYCLES);
        else if (pulse_cnt != 0) pulse_cnt <= pulse_cnt - 1'b1;
    end

    assign nmi_req = (pulse_cnt != 0);
    assign rd_byte = !rd_strobe ? '0 : (hi_sel ? pc_q[2*DW-1:DW] : pc_q[DW-1:0]);

endmodule

// File: rtl/brk_pc_unit.sv
// Module brk_pc_unit (top)
// Address/manual breakpoint with deferred NMI and PC capture.
// Control port writes set the address and the mode. A trigger is held
// pending until the next opcode fetch, which fires the break.
// Assumes bus_fetch comes with the fetch address on bus_addr.
module brk_pc_unit
    import brk_pkg::*;
#(
    parameter int         DW          = 8,
    parameter int         NMI_CYCLES  = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] PORT_PC     = 8'hF2,
    parameter logic [7:0] PORT_AHI    = 8'hFC,
    parameter logic [7:0] PORT_ALO    = 8'hFD,
    parameter logic [7:0] PORT_MODE   = 8'hFE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [7:0]      io_addr,
    input  logic [DW-1:0]   io_wdata,
    output logic [DW-1:0]   rd_data,
    input  logic [2*DW-1:0] bus_addr,
    input  logic            bus_mem,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic            bus_fetch,
    input  logic            brk_btn,
    output logic            nmi_req
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] brk_addr;
    brk_kind_e     kind;
    logic          armed;
    logic          pending;
    logic          hit;
    logic          press;
    logic          fire;
    logic          mode_wr;
    logic          rd_strobe;

    assign mode_wr   = io_wr & (io_addr == PORT_MODE);
    assign rd_strobe = io_rd & (io_addr == PORT_PC);
    assign fire      = armed & pending & bus_fetch;

    // Break address register, loaded one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_addr <= '0;
        end else if (io_wr && io_addr == PORT_AHI) begin
            brk_addr[AW-1:DW] <= io_wdata;
        end else if (io_wr && io_addr == PORT_ALO) begin
            brk_addr[DW-1:0] <= io_wdata;
        end
    end

    // Mode register, holding the decoded break kind.
    always_ff @(posedge clk) begin
        if (!rst_n)       kind <= BK_NONE;
        else if (mode_wr) kind <= decode_kind(io_wdata[7:0]);
    end

    // Arm state: set by a mode write, cleared by a break.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (mode_wr) armed <= 1'b1;
        else if (fire)    armed <= 1'b0;
    end

    // Pending trigger, waiting for the end of the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pending <= 1'b0;
        else if (mode_wr || fire)       pending <= 1'b0;
        else if (armed && (hit || press)) pending <= 1'b1;
    end

    brk_btn_sync #(
        .STAGES (SYNC_STAGES)
    ) u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_raw (brk_btn),
        .press   (press)
    );

    brk_match #(
        .AW (AW)
    ) u_match (
        .kind     (kind),
        .brk_addr (brk_addr),
        .bus_addr (bus_addr),
        .bus_mem  (bus_mem),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .hit      (hit)
    );

    brk_capture #(
        .DW         (DW),
        .NMI_CYCLES (NMI_CYCLES)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .fetch_addr (bus_addr),
        .rd_strobe  (rd_strobe),
        .nmi_req    (nmi_req),
        .rd_byte    (rd_data)
    );

endmodule

// File: rtl/brk_pc_unit_chk.sv
// Module brk_pc_unit_chk
// Property checker for brk_pc_unit, attached with bind.
// Assumes no re-arm and second break during an NMI pulse.
module brk_pc_unit_chk #(
    parameter int         DW         = 8,
    parameter int         NMI_CYCLES = 4,
    parameter logic [7:0] PORT_PC    = 8'hF2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nmi_req,
    input logic          bus_fetch,
    input logic          io_rd,
    input logic [7:0]    io_addr,
    input logic [DW-1:0] rd_data,
    input logic          armed,
    input logic          pending
);
    int unsigned run_len;

    // Length of the current run of high nmi_req cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_len <= 0;
        else if (nmi_req) run_len <= run_len + 1;
        else              run_len <= 0;
    end

    // R5: the pulse is never longer than NMI_CYCLES, and never ends early.
    always_ff @(posedge clk) begin
        if (rst_n && nmi_req) begin
            p_pulse_max_r5: assert (run_len < NMI_CYCLES);
        end
        if (rst_n && !nmi_req && run_len != 0) begin
            p_pulse_full_r5: assert (run_len == NMI_CYCLES);
        end
    end

    p_rise_on_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past(bus_fetch));

    p_fire_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> ($past(armed) && $past(pending)));

    p_disarm_on_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> !pending);

    p_pending_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> armed);

    p_rd_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == PORT_PC) |-> (rd_data == '0));

endmodule

bind brk_pc_unit brk_pc_unit_chk #(
    .DW         (DW),
    .NMI_CYCLES (NMI_CYCLES),
    .PORT_PC    (PORT_PC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_req   (nmi_req),
    .bus_fetch (bus_fetch),
    .io_rd     (io_rd),
    .io_addr   (io_addr),
    .rd_data   (rd_data),
    .armed     (armed),
    .pending   (pending)
);

// File: tb/tb_brk_pc_unit.sv
`timescale 1ns/1ps
module tb_brk_pc_unit;
    localparam int NMI_N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_addr = 8'h00, io_wdata = 8'h00;
    logic [7:0]  rd_data;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_mem = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_fetch = 1'b0;
    logic        brk_btn = 1'b0;
    logic        nmi_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    brk_pc_unit #(.NMI_CYCLES(NMI_N)) dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_mem(bus_mem), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_fetch(bus_fetch), .brk_btn(brk_btn),
        .nmi_req(nmi_req)
    );

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    int   m_kind;          // 0 none, 1 mrd, 2 mwr, 3 iin, 4 iout
    int   m_addr, m_pc, m_cnt;
    bit   m_armed, m_pend, m_hi;
    bit   b1, b2, b3;

    function automatic int kind_of(input int code);
        if (code == 'h0A) return 1;
        if (code == 'h06) return 2;
        if (code == 'h09) return 3;
        if (code == 'h05) return 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit press, hit, fire, mwr, rdp;
        if (!rst_n) begin
            m_kind <= 0; m_addr <= 0; m_pc <= 0; m_cnt <= 0;
            m_armed <= 0; m_pend <= 0; m_hi <= 0;
            b1 <= 0; b2 <= 0; b3 <= 0;
        end else begin
            press = b2 && !b3;
            hit = (int'(bus_addr) == m_addr) &&
                  ((m_kind == 1 && bus_mem && bus_rd) || (m_kind == 2 && bus_mem && bus_wr) ||
                   (m_kind == 3 && !bus_mem && bus_rd) || (m_kind == 4 && !bus_mem && bus_wr));
            fire = m_armed && m_pend && bus_fetch;
            mwr  = io_wr && io_addr == 8'hFE;
            rdp  = io_rd && io_addr == 8'hF2;
            b1 <= brk_btn; b2 <= b1; b3 <= b2;
            if (io_wr && io_addr == 8'hFC) m_addr <= (m_addr % 256) + 256 * int'(io_wdata);
            if (io_wr && io_addr == 8'hFD) m_addr <= (m_addr / 256) * 256 + int'(io_wdata);
            if (mwr) m_kind <= kind_of(int'(io_wdata));
            if (mwr) m_armed <= 1; else if (fire) m_armed <= 0;
            if (mwr || fire) m_pend <= 0; else if (m_armed && (hit || press)) m_pend <= 1;
            if (fire) m_pc <= int'(bus_addr);
            if (fire) m_hi <= 0; else if (rdp) m_hi <= !m_hi;
            if (fire) m_cnt <= NMI_N; else if (m_cnt > 0) m_cnt <= m_cnt - 1;
        end
    end

    // Clock-by-clock comparison against the model, away from the edge.
    always @(negedge clk) begin
        int exp_rd;
        if (rst_n && !done) begin
            exp_rd = (io_rd && io_addr == 8'hF2) ? (m_hi ? m_pc / 256 : m_pc % 256) : 0;
            total++;
            if (nmi_req !== (m_cnt > 0)) begin
                bad++;
                $display("FAIL R5 nmi_req model compare got=%0d exp=%0d t=%0t", nmi_req, m_cnt > 0, $time);
            end
            total++;
            if (int'(rd_data) != exp_rd) begin
                bad++;
                $display("FAIL R6 rd_data model compare got=%02h exp=%02h t=%0t", rd_data, exp_rd, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick();
        @(posedge clk); #2;
        cyc++;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic port_wr(input logic [7:0] a, input logic [7:0] d);
        io_wr = 1; io_addr = a; io_wdata = d;
        tick();
        io_wr = 0; io_addr = 8'h00;
    endtask

    task automatic port_rd(input string req, input int exp);
        io_rd = 1; io_addr = 8'hF2;
        #1 chk(req, int'(rd_data), exp);
        tick();
        io_rd = 0; io_addr = 8'h00;
    endtask

    task automatic acc(input logic [15:0] a, input bit mem, input bit rd, input bit wr, input bit f);
        bus_addr = a; bus_mem = mem; bus_rd = rd; bus_wr = wr; bus_fetch = f;
        tick();
        bus_addr = 16'h0; bus_mem = 0; bus_rd = 0; bus_wr = 0; bus_fetch = 0;
    endtask

    task automatic fetch(input logic [15:0] a);
        acc(a, 1, 1, 0, 1);
    endtask

    // Fetch, then check whether a pulse of full length followed.
    task automatic fetch_expect(input string req, input logic [15:0] a, input bit brk);
        int hi_cnt;
        fetch(a);
        hi_cnt = 0;
        for (int i = 0; i < NMI_N + 2; i++) begin
            if (nmi_req) hi_cnt++;
            tick();
        end
        chk(req, hi_cnt, brk ? NMI_N : 0);
    endtask

    task automatic set_addr(input logic [15:0] a);
        port_wr(8'hFC, a[15:8]);
        port_wr(8'hFD, a[7:0]);
    endtask

    // Watchdog.
    initial begin
        #1000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1 nmi after reset", int'(nmi_req), 0);
        port_rd("R1 captured pc low after reset", 0);
        // R1: not armed, address ports alone do not arm
        set_addr(16'h1234);
        acc(16'h1234, 1, 1, 0, 0);
        brk_btn = 1; repeat (5) tick(); brk_btn = 0; repeat (3) tick();
        fetch_expect("R1 no break while disarmed", 16'h2000, 0);

        // R2 R3 R4 R5 R6: memory read break
        port_wr(8'hFE, 8'h0A);
        acc(16'h1235, 1, 1, 0, 0);
        fetch_expect("R2 other address ignored", 16'h2000, 0);
        acc(16'h1234, 1, 1, 0, 0);
        acc(16'h1234, 1, 0, 0, 0);
        chk("R4 nmi waits for fetch", int'(nmi_req), 0);
        fetch_expect("R3 memory read break", 16'h2000, 1);
        port_rd("R6 low byte first", 8'h00);
        port_rd("R6 high byte second", 8'h20);
        port_rd("R6 wraps to low", 8'h00);

        // R7: disarmed after the break
        acc(16'h1234, 1, 1, 0, 0);
        fetch_expect("R7 no break until re-armed", 16'h2100, 0);

        // R4: the fetch that matches does not complete itself
        port_wr(8'hFE, 8'h0A);
        fetch_expect("R4 same-cycle fetch ignored", 16'h1234, 0);
        fetch_expect("R4 next fetch breaks", 16'h1237, 1);
        port_rd("R6 low byte 1237", 8'h37);
        // R6: capture resets the order even after an odd read count
        port_wr(8'hFE, 8'h0A);
        acc(16'h1234, 1, 1, 0, 0);
        fetch_expect("R6 recapture", 16'hBEEF, 1);
        port_rd("R6 order reset low", 8'hEF);
        port_rd("R6 order reset high", 8'hBE);

        // R3: memory write
        set_addr(16'hA55A);
        port_wr(8'hFE, 8'h06);
        acc(16'hA55A, 0, 0, 1, 0);
        acc(16'hA55A, 1, 1, 0, 0);
        fetch_expect("R3 mem write ignores others", 16'h3000, 0);
        acc(16'hA55A, 1, 0, 1, 0);
        fetch_expect("R3 memory write break", 16'h3001, 1);

        // R3: I/O input
        port_wr(8'hFE, 8'h09);
        acc(16'hA55A, 1, 1, 0, 0);
        acc(16'hA55A, 0, 0, 1, 0);
        fetch_expect("R3 io input ignores others", 16'h3002, 0);
        acc(16'hA55A, 0, 1, 0, 0);
        fetch_expect("R3 io input break", 16'h3003, 1);

        // R3: I/O output
        port_wr(8'hFE, 8'h05);
        acc(16'hA55A, 0, 1, 0, 0);
        fetch_expect("R3 io output ignores input", 16'h3004, 0);
        acc(16'hA55A, 0, 0, 1, 0);
        fetch_expect("R3 io output break", 16'h3005, 1);
        port_rd("R6 low 3005", 8'h05);
        port_rd("R6 high 3005", 8'h30);

        // R3: undefined and zero codes disable
        foreach (bus_addr[i]) begin end
        port_wr(8'hFE, 8'h07);
        acc(16'hA55A, 1, 1, 0, 0); acc(16'hA55A, 1, 0, 1, 0);
        acc(16'hA55A, 0, 1, 0, 0); acc(16'hA55A, 0, 0, 1, 0);
        fetch_expect("R3 code 07 disables", 16'h3006, 0);
        port_wr(8'hFE, 8'h00);
        acc(16'hA55A, 1, 1, 0, 0); acc(16'hA55A, 0, 0, 1, 0);
        fetch_expect("R3 code 00 disables", 16'h3007, 0);

        // R8: button with mode 00, one press one break
        brk_btn = 1; repeat (6) tick();
        chk("R8 button waits for fetch", int'(nmi_req), 0);
        fetch_expect("R8 button break", 16'h4000, 1);
        port_wr(8'hFE, 8'h00);
        fetch_expect("R8 held button no second break", 16'h4001, 0);
        brk_btn = 0; repeat (4) tick();
        fetch_expect("R8 release gives no break", 16'h4002, 0);

        // R7: mode write drops a pending trigger
        port_wr(8'hFE, 8'h0A);
        acc(16'hA55A, 1, 1, 0, 0);
        port_wr(8'hFE, 8'h0A);
        fetch_expect("R7 re-arm clears pending", 16'h4003, 0);

        // R9: other ports have no effect
        port_wr(8'hF0, 8'hFF);
        port_wr(8'hF2, 8'h11);
        port_wr(8'hFB, 8'h22);
        acc(16'hA55A, 1, 1, 0, 0);
        fetch_expect("R9 address and mode kept", 16'h5000, 1);
        io_rd = 1; io_addr = 8'hF3;
        #1 chk("R9 rd_data zero on other port", int'(rd_data), 0);
        tick(); io_rd = 0; io_addr = 8'h00;
        port_rd("R9 capture unchanged", 8'h00);
        port_rd("R9 capture high", 8'h50);

        repeat (3) tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule